// File: doc/BRIEF.md
# Receiver Error Sample Hold

This block sits in the receive audio path, after the stage that decodes a digital audio stream and before the serial port that sends samples onward. Each stereo frame arrives as a left sample, a right sample and a vector of error flags. The flags cover faults such as lost lock, parity, bi-phase coding, low confidence and a cleared validity bit. A mask input decides which flags are allowed to count. A frame that carries at least one flag allowed by the mask is *qualified*. For a qualified frame, a two-bit policy input sets what the block sends out:

- the last clean frame, repeated;
- zeros;
- or the received samples, unchanged.

The block also keeps sticky status bits for the qualified flags and drives an interrupt line from them. A separate flag reports digital silence: it rises once a long run of all-zero frames has been seen.

Frames enter and leave on valid/ready streams, and one output register sits between the two. The upstream side sees `in_ready` high whenever the output register is empty or is being emptied in the same cycle, so back-pressure passes through in the same cycle. A frame is accepted on a rising clock edge where both `in_valid` and `in_ready` are high. A frame is delivered on an edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the presented frame does not change. Control inputs and status outputs are plain levels.

Top module: `rx_err_hold`

## Requirements
- R1: Each accepted frame produces exactly one output frame, and frames leave in the order they were accepted. `in_ready` is high when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` stay unchanged.
- R2: With policy code 2'b00, a qualified frame is sent out as the most recent clean frame on both channels. Before any clean frame has been accepted, that is zero.
- R3: With policy code 2'b01, a qualified frame is sent out as zero on both channels.
- R4: With policy code 2'b10, and with the spare code 2'b11, a qualified frame is sent out unchanged.
- R5: The stored clean frame is taken from every accepted frame that has no qualified flag. It is never taken from a qualified frame.
- R6: Flag bit i counts only when mask bit i is 1. A qualified flag bit i sets `err_status[i]`, which stays set afterwards. `err_irq` is high whenever any `err_status` bit is set.
- R7: A flag whose mask bit is 0 has no effect on `err_status`, on `err_irq` or on the output samples.
- R8: A high `stat_clr` at a clock edge clears `err_status`. A qualified flag accepted at that same edge is still recorded.
- R9: `silence` rises after SILENCE_RUN consecutive accepted frames in which both channels are zero, with SILENCE_RUN defaulting to 1548. It stays high while such frames keep arriving. It drops after any accepted frame in which either channel is nonzero.
- R10: After reset, `out_valid`, `err_status`, `err_irq` and `silence` are all 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_mode | input | 2 | Substitution policy for qualified frames |
| err_mask | input | NUM_ERR | Per-flag enable |
| stat_clr | input | 1 | Clears sticky status |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame can be taken |
| in_left | input | SAMPLE_W | Received left sample |
| in_right | input | SAMPLE_W | Received right sample |
| in_err | input | NUM_ERR | Error flags for this frame |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Downstream takes output |
| out_left | output | SAMPLE_W | Outgoing left sample |
| out_right | output | SAMPLE_W | Outgoing right sample |
| err_status | output | NUM_ERR | Sticky qualified-flag status |
| err_irq | output | 1 | Any status bit set |
| silence | output | 1 | Digital silence detected |

## Verification
Several rules are checked by assertions on every cycle:
- the output stays stable while stalled;
- status bits only ever stay set, and clear only on `stat_clr`;
- the interrupt follows any qualified flag;
- the zero policy and the pass policy produce the right output;
- a frame with no qualified flag passes through unchanged;
- `silence` falls after any nonzero frame.

Other behaviour can only be shown by the bench's scenarios, which compare each frame against a reference model fed through a queue. These cover the repeat of the last clean frame, including its zero value after reset, and the order of frames under random stalls. They also cover the exact frame count at which `silence` first rises and its hold while zeros continue, and the rule that a set and a clear at the same edge leave the bit set.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  typedef enum logic [1:0] {
    HOLD_LAST = 2'b00,
    HOLD_ZERO = 2'b01,
    HOLD_PASS = 2'b10,
    HOLD_SPARE = 2'b11
  } hold_mode_e;

  // The spare code behaves as pass-through.
  function automatic hold_mode_e eff_mode(input logic [1:0] code);
    case (code)
      2'b00:   eff_mode = HOLD_LAST;
      2'b01:   eff_mode = HOLD_ZERO;
      default: eff_mode = HOLD_PASS;
    endcase
  endfunction
endpackage

// File: rtl/rxh_qualify.sv
module rxh_qualify #(
  parameter int NUM_ERR = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [NUM_ERR-1:0] in_err,
  input  logic [NUM_ERR-1:0] err_mask,
  input  logic               stat_clr,
  output logic               qual,
  output logic [NUM_ERR-1:0] err_status,
  output logic               err_irq
);
  logic [NUM_ERR-1:0] hits;
  logic [NUM_ERR-1:0] status_q;

  assign hits = in_err & err_mask;
  assign qual = |hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (stat_clr ? '0 : status_q) | (fire ? hits : '0);
    end
  end

  assign err_status = status_q;
  assign err_irq    = |status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((err_status & $past(err_status)) == $past(err_status))); // R6
  AST_IRQ_ON_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && qual) |=> err_irq); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !fire) |=> (err_status == '0)); // R8
endmodule

// File: rtl/rxh_substitute.sv
module rxh_substitute
  import rxh_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NUM_CH   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fire,
  input  logic                           qual,
  input  logic [1:0]                     hold_mode,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] in_smp,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0] sub_smp
);
  logic [NUM_CH-1:0][SAMPLE_W-1:0] last_good;
  hold_mode_e mode;

  assign mode = eff_mode(hold_mode);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_good[c] <= '0;
      end else if (fire && !qual) begin
        last_good[c] <= in_smp[c];
      end
    end

    always_comb begin
      if (!qual) begin
        sub_smp[c] = in_smp[c];
      end else begin
        case (mode)
          HOLD_LAST: sub_smp[c] = last_good[c];
          HOLD_ZERO: sub_smp[c] = '0;
          default:   sub_smp[c] = in_smp[c];
        endcase
      end
    end
  end

  AST_LAST_KEPT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && qual) |=> $stable(last_good)); // R5
endmodule

// File: rtl/rxh_silence.sv
module rxh_silence #(
  parameter int SAMPLE_W    = 24,
  parameter int NUM_CH      = 2,
  parameter int SILENCE_RUN = 1548
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fire,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] in_smp,
  output logic                           silence
);
  localparam int CW = $clog2(SILENCE_RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(SILENCE_RUN);

  logic [CW-1:0] run_cnt;
  logic          all_zero;

  assign all_zero = (in_smp == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (fire) begin
      if (!all_zero)            run_cnt <= '0;
      else if (run_cnt != RUN_C) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign silence = (run_cnt == RUN_C);

  AST_SIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !all_zero) |=> !silence); // R9
  AST_SIL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_C); // R9
endmodule

// File: rtl/rxh_out_stage.sv
module rxh_out_stage #(
  parameter int SAMPLE_W = 24,
  parameter int NUM_CH   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] in_smp,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0] out_smp
);
  logic                           vld_q;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      smp_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) smp_q <= in_smp;
    end
  end

  assign out_valid = vld_q;
  assign out_smp   = smp_q;

  AST_OUT_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_smp))); // R1
endmodule

// File: rtl/rx_err_hold.sv
module rx_err_hold
  import rxh_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int NUM_ERR     = 5,
  parameter int SILENCE_RUN = 1548
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          hold_mode,
  input  logic [NUM_ERR-1:0]  err_mask,
  input  logic                stat_clr,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [NUM_ERR-1:0]  in_err,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic [NUM_ERR-1:0]  err_status,
  output logic                err_irq,
  output logic                silence
);
  localparam int NUM_CH = 2;

  logic                           fire;
  logic                           qual;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] rx_smp;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] sub_smp;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] tx_smp;

  assign rx_smp[0] = in_left;
  assign rx_smp[1] = in_right;
  assign fire      = in_valid && in_ready;

  rxh_qualify #(.NUM_ERR(NUM_ERR)) u_qual (
    .clk(clk), .rst_n(rst_n), .fire(fire), .in_err(in_err),
    .err_mask(err_mask), .stat_clr(stat_clr), .qual(qual),
    .err_status(err_status), .err_irq(err_irq)
  );

  rxh_substitute #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_sub (
    .clk(clk), .rst_n(rst_n), .fire(fire), .qual(qual),
    .hold_mode(hold_mode), .in_smp(rx_smp), .sub_smp(sub_smp)
  );

  rxh_silence #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .SILENCE_RUN(SILENCE_RUN)) u_sil (
    .clk(clk), .rst_n(rst_n), .fire(fire), .in_smp(rx_smp), .silence(silence)
  );

  rxh_out_stage #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_smp(sub_smp), .out_valid(out_valid), .out_ready(out_ready), .out_smp(tx_smp)
  );

  assign out_left  = tx_smp[0];
  assign out_right = tx_smp[1];

  AST_ZERO_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && qual && hold_mode == 2'b01) |=>
      (out_valid && out_left == '0 && out_right == '0)); // R3
  AST_PASS_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hold_mode[1]) |=>
      (out_valid && out_left == $past(in_left) && out_right == $past(in_right))); // R4
  AST_UNQUAL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_err & err_mask) == '0) |=>
      (out_left == $past(in_left) && out_right == $past(in_right))); // R7
endmodule

// File: tb/rx_err_hold_bench.sv
`timescale 1ns/1ps
module rx_err_hold_bench;
  localparam int W  = 24;
  localparam int NE = 5;
  localparam int RUN = 1548;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] hold_mode = 2'b00;
  logic [NE-1:0] err_mask = '1;
  logic stat_clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic [NE-1:0] in_err = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_left, out_right;
  logic [NE-1:0] err_status;
  logic err_irq, silence;

  always #2.5 clk = ~clk;

  rx_err_hold #(.SAMPLE_W(W), .NUM_ERR(NE), .SILENCE_RUN(RUN)) u_rx_err_hold (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .err_mask(err_mask),
    .stat_clr(stat_clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .err_status(err_status), .err_irq(err_irq),
    .silence(silence)
  );

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  int cyc = 0;
  logic [2*W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] m_last_l = '0, m_last_r = '0;
  logic [NE-1:0] m_status = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: computes expected output from the requirements and queues it.
  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r, input logic [NE-1:0] e,
                      input string tag);
    logic q;
    logic [W-1:0] xl, xr;
    @(negedge clk); #1;
    in_valid = 1'b1; in_left = l; in_right = r; in_err = e;
    while (!in_ready) begin @(negedge clk); #1; end
    q = |(e & err_mask);
    if (!q) begin
      xl = l; xr = r; m_last_l = l; m_last_r = r;
    end else if (hold_mode == 2'b00) begin
      xl = m_last_l; xr = m_last_r;
    end else if (hold_mode == 2'b01) begin
      xl = '0; xr = '0;
    end else begin
      xl = l; xr = r;
    end
    m_status = m_status | (e & err_mask);
    exp_q.push_back({xl, xr});
    tag_q.push_back(tag);
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: drives back-pressure and compares delivered frames.
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    out_ready = !stall_en || lfsr[0];
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected output", {out_left, out_right}, 64'h0);
      end else begin
        logic [2*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_left, out_right} == e, t, {out_left, out_right}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hang expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(err_status == 0, "R10 err_status", err_status, 0);
    chk(err_irq == 0, "R10 err_irq", err_irq, 0);
    chk(silence == 0, "R10 silence", silence, 0);
    chk(in_ready == 1, "R10 in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R2: error before any clean frame repeats zero
    hold_mode = 2'b00; err_mask = '1;
    send(24'h111111, 24'h222222, 5'b00100, "R2 hold before clean");
    send(24'h0A0A0A, 24'h0B0B0B, 5'b00000, "R5 clean frame");
    send(24'h333333, 24'h444444, 5'b00001, "R2 hold last clean");
    send(24'h555555, 24'h666666, 5'b10000, "R5 last kept across error");
    // R3
    hold_mode = 2'b01;
    send(24'h777777, 24'h888888, 5'b01000, "R3 zero on error");
    send(24'h123456, 24'h654321, 5'b00000, "R3 clean unaffected");
    // R4
    hold_mode = 2'b10;
    send(24'h999999, 24'hAAAAAA, 5'b00010, "R4 pass code 10");
    hold_mode = 2'b11;
    send(24'hBBBBBB, 24'hCCCCCC, 5'b00010, "R4 pass code 11");
    hold_mode = 2'b00;
    send(24'hDDDDDD, 24'hEEEEEE, 5'b00010, "R5 last is pre-pass clean frame");
    drain();
    chk(err_status == m_status, "R6 sticky status", err_status, m_status);
    chk(err_irq == 1, "R6 irq", err_irq, 1);

    // R8 clear, then set-and-clear at same edge
    @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    m_status = '0;
    chk(err_status == 0, "R8 clear", err_status, 0);
    chk(err_irq == 0, "R8 irq after clear", err_irq, 0);
    stat_clr = 1'b1;
    send(24'h010101, 24'h020202, 5'b00100, "R8 frame during clear");
    stat_clr = 1'b0;
    drain();
    chk(err_status == 5'b00100, "R8 set wins", err_status, 5'b00100);
    @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    m_status = '0;

    // R7 masked-off flag ignored, frame counts as clean
    err_mask = 5'b00001; hold_mode = 2'b01;
    send(24'h0F0F0F, 24'hF0F0F0, 5'b11110, "R7 masked flag no effect");
    drain();
    chk(err_status == 0, "R7 status untouched", err_status, 0);
    chk(err_irq == 0, "R7 irq untouched", err_irq, 0);
    hold_mode = 2'b00;
    send(24'h000001, 24'h000002, 5'b00001, "R7 masked frame became last clean");
    drain();
    chk(err_status == 5'b00001, "R6 unmasked bit recorded", err_status, 5'b00001);
    @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    m_status = '0;

    // R1 random stream under back-pressure
    stall_en = 1'b1; err_mask = '1;
    for (int i = 0; i < 300; i++) begin
      hold_mode = lfsr[9:8];
      send(W'(lfsr * 7 + i), W'(lfsr ^ i), (lfsr[12:10] == 0) ? NE'(lfsr[20:16]) : '0, "R1 stream order");
    end
    drain();
    chk(err_status == m_status, "R6 status after stream", err_status, m_status);
    stall_en = 1'b0;

    // R9 silence
    send(24'h1, 24'h0, '0, "R9 seed nonzero");
    for (int i = 0; i < RUN - 1; i++) send('0, '0, '0, "R9 zero frame");
    chk(silence == 0, "R9 one short of run", silence, 0);
    send('0, '0, '0, "R9 zero frame");
    chk(silence == 1, "R9 run reached", silence, 1);
    send('0, '0, '0, "R9 zero frame");
    chk(silence == 1, "R9 saturated hold", silence, 1);
    send('0, 24'h000010, '0, "R9 right nonzero");
    chk(silence == 0, "R9 drop on nonzero", silence, 0);
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule